// File: doc/BRIEF.md
# Configurable Lookup / Memory / Delay Cell

This block is a single 16-bit storage cell whose contents serve one of four purposes, chosen at run time by a 2-bit mode input. It can act as a 4-input logic function whose truth table sits in the store, or as a 16x1 memory with one address port. It can also be a 16x1 memory with an extra read-only port, or a serial delay line whose output tap is picked by the address. The store is filled through a serial configuration path. Changing the mode leaves the stored bits untouched, so a table loaded for logic use can later be read or patched as memory.

Both read ports use the same structure. A decoder turns the address into a one-hot vector holding every product term of the address bits. A selector then ANDs that vector with the store and ORs the result onto the output. The port-A decoder output also picks the bit that a memory write updates.

Top module: `cfg_lut_cell`

## Requirements
- R1: A synchronous active-high reset clears all 16 stored bits to 0. While the store is zero, `out_a` reads 0.
- R2: While `cfg_load` is high, each rising edge shifts `cfg_bit` into index 15 and moves every other bit one index down. After 16 loads, the first bit sent sits at index 0. This path wins over `wr_en` in every mode.
- R3: In every mode, `out_a` equals the stored bit at index `addr`, combinationally.
- R4: In lookup mode (`mode_sel` = 00), `wr_en` has no effect on the stored bits. Loading a 16-bit truth table therefore makes `out_a` any 4-input function of `addr`.
- R5: In single-port mode (`mode_sel` = 01), a rising edge with `wr_en` high stores `wr_data` at index `addr`, and no other bit changes. With `wr_en` low, nothing changes.
- R6: In dual-port mode (`mode_sel` = 10), writes behave as in R5, and `out_b` equals the stored bit at index `rd_addr2`. When `rd_addr2` equals the address being written, `out_b` shows the old value until the edge and the new value after it.
- R7: In any mode other than 10, `out_b` is 0.
- R8: In shift mode (`mode_sel` = 11), a rising edge with `wr_en` high moves every bit one index up and puts `wr_data` into index 0. A bit written on an edge then appears on `out_a` with `addr` = k after k further shifting edges, which gives a delay of 1 to 16 edges. With `wr_en` low, nothing shifts.
- R9: Changing `mode_sel` does not alter the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears the store |
| mode_sel | input | 2 | 00 lookup, 01 single-port RAM, 10 dual-port RAM, 11 shift |
| cfg_load | input | 1 | Serial configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data, enters at index 15 |
| wr_en | input | 1 | Write or shift enable |
| addr | input | 4 | Lookup inputs, read/write address or shift tap |
| wr_data | input | 1 | Write data or shift input |
| rd_addr2 | input | 4 | Second read address (dual-port mode) |
| out_a | output | 1 | Stored bit at `addr` |
| out_b | output | 1 | Stored bit at `rd_addr2` in dual-port mode, else 0 |

## Verification
The bench builds the cell with the default select width of 4, so the store has 16 entries. At that size every address can be visited. A single marker bit can be pushed through all 16 shift positions and then out of the end, which covers both the shortest and the longest tap delay. A complete 16-bit truth table can also be loaded serially, which shows that the first configuration bit lands at index 0.

// File: rtl/cfg_cell_pkg.sv
package cfg_cell_pkg;

    typedef enum logic [1:0] {
        MODE_LUT   = 2'b00,
        MODE_SPRAM = 2'b01,
        MODE_DPRAM = 2'b10,
        MODE_SHIFT = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic load;
        logic data;
    } cfg_req_t;

    typedef struct packed {
        logic en;
        logic data;
    } wr_req_t;

    function automatic logic mode_is_ram(input cell_mode_e m);
        return (m == MODE_SPRAM) || (m == MODE_DPRAM);
    endfunction

endpackage

// File: rtl/cell_decoder.sv
module cell_decoder #(
    parameter int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [DEPTH-1:0] onehot
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_term
        assign onehot[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/cell_selector.sv
module cell_selector #(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0] onehot,
    input  logic [DEPTH-1:0] bits,
    output logic             dout
);
    assign dout = |(onehot & bits);
endmodule

// File: rtl/cell_store.sv
module cell_store
    import cfg_cell_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cell_mode_e       mode,
    input  cfg_req_t         cfg,
    input  wr_req_t          wr,
    input  logic [DEPTH-1:0] wr_sel,
    output logic [DEPTH-1:0] store_q
);
    logic [DEPTH-1:0] shift_nxt;
    logic [DEPTH-1:0] cfg_nxt;
    logic [DEPTH-1:0] ram_nxt;

    for (genvar i = 0; i < DEPTH; i++) begin : g_bit
        if (i == 0) begin : g_head
            assign shift_nxt[i] = wr.data;
        end else begin : g_body
            assign shift_nxt[i] = store_q[i-1];
        end
        if (i == DEPTH - 1) begin : g_cfg_top
            assign cfg_nxt[i] = cfg.data;
        end else begin : g_cfg_body
            assign cfg_nxt[i] = store_q[i+1];
        end
        assign ram_nxt[i] = wr_sel[i] ? wr.data : store_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else if (cfg.load) begin
            store_q <= cfg_nxt;
        end else if (wr.en) begin
            if (mode == MODE_SHIFT) begin
                store_q <= shift_nxt;
            end else if (mode_is_ram(mode)) begin
                store_q <= ram_nxt;
            end
        end
    end
endmodule

// File: rtl/cfg_lut_cell.sv
module cfg_lut_cell
    import cfg_cell_pkg::*;
#(
    parameter int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] addr,
    input  logic             wr_data,
    input  logic [SEL_W-1:0] rd_addr2,
    output logic             out_a,
    output logic             out_b
);
    localparam int NPORT = 2;

    cell_mode_e       mode;
    cfg_req_t         cfg;
    wr_req_t          wr;
    logic [DEPTH-1:0] store_q;
    logic [SEL_W-1:0] port_addr [NPORT];
    logic [DEPTH-1:0] port_hot  [NPORT];
    logic             port_dout [NPORT];

    assign mode         = cell_mode_e'(mode_sel);
    assign cfg          = '{load: cfg_load, data: cfg_bit};
    assign wr           = '{en: wr_en, data: wr_data};
    assign port_addr[0] = addr;
    assign port_addr[1] = rd_addr2;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        cell_decoder #(.SEL_W(SEL_W)) u_dec (
            .sel    (port_addr[p]),
            .onehot (port_hot[p])
        );
        cell_selector #(.DEPTH(DEPTH)) u_sel (
            .onehot (port_hot[p]),
            .bits   (store_q),
            .dout   (port_dout[p])
        );
    end

    cell_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .cfg     (cfg),
        .wr      (wr),
        .wr_sel  (port_hot[0]),
        .store_q (store_q)
    );

    assign out_a = port_dout[0];
    assign out_b = (mode == MODE_DPRAM) && port_dout[1];
endmodule

// File: rtl/cfg_lut_cell_chk.sv
module cfg_lut_cell_chk #(
    parameter int SEL_W = 4,
    localparam int DEPTH = 1 << SEL_W
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_sel,
    input logic             cfg_load,
    input logic             cfg_bit,
    input logic             wr_en,
    input logic [SEL_W-1:0] addr,
    input logic             wr_data,
    input logic [SEL_W-1:0] rd_addr2,
    input logic             out_a,
    input logic             out_b,
    input logic [DEPTH-1:0] store_q
);
    p_cfg_shift_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (store_q[DEPTH-1] == $past(cfg_bit)) &&
                     (store_q[DEPTH-2:0] == $past(store_q[DEPTH-1:1])));

    p_read_a_r3: assert property (@(posedge clk) disable iff (rst)
        out_a == store_q[addr]);

    p_lut_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load && mode_sel == 2'b00) |=> $stable(store_q));

    p_ram_write_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load && wr_en && (mode_sel == 2'b01 || mode_sel == 2'b10))
        |=> store_q[$past(addr)] == $past(wr_data));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load && !wr_en) |=> $stable(store_q));

    p_port_b_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b10) |-> out_b == store_q[rd_addr2]);

    p_port_b_off_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != 2'b10) |-> !out_b);

    p_shift_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_load && wr_en && mode_sel == 2'b11)
        |=> store_q == {$past(store_q[DEPTH-2:0]), $past(wr_data)});
endmodule

bind cfg_lut_cell cfg_lut_cell_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .cfg_load (cfg_load),
    .cfg_bit  (cfg_bit),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_addr2 (rd_addr2),
    .out_a    (out_a),
    .out_b    (out_b),
    .store_q  (store_q)
);

// File: tb/cfg_lut_cell_tb.sv
module cfg_lut_cell_tb;
    localparam int SEL_W = 4;
    localparam int NVEC  = 8;
    localparam int WATCHDOG_CYC = 200000;

    // vector: {addr[3:0], wr_data, expected out_a}; table is 4-input parity
    localparam logic [5:0] LUT_VEC [NVEC] = '{
        6'b0000_1_0, 6'b0001_0_1, 6'b0110_1_0, 6'b0111_0_1,
        6'b1001_1_0, 6'b1011_0_1, 6'b1101_0_1, 6'b1111_1_0
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       mode_sel = 2'b00;
    logic             cfg_load = 1'b0;
    logic             cfg_bit = 1'b0;
    logic             wr_en = 1'b0;
    logic [SEL_W-1:0] addr = '0;
    logic             wr_data = 1'b0;
    logic [SEL_W-1:0] rd_addr2 = '0;
    logic             out_a;
    logic             out_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cfg_lut_cell #(.SEL_W(SEL_W)) u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .cfg_load(cfg_load),
        .cfg_bit(cfg_bit), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_addr2(rd_addr2), .out_a(out_a), .out_b(out_b)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cfg_fill(input logic [15:0] val);
        for (int i = 0; i < 16; i++) begin
            cfg_load = 1'b1;
            cfg_bit  = val[i];
            tick();
        end
        cfg_load = 1'b0;
    endtask

    initial begin
        #(4 * WATCHDOG_CYC);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        addr = 4'd5;
        #1;
        check("R1 reset clear", out_a, 1'b0);
        check("R7 port b off in lookup", out_b, 1'b0);

        // R2: serial load of parity table, with wr_en held high to test priority
        mode_sel = 2'b01;
        wr_en    = 1'b1;
        wr_data  = 1'b1;
        addr     = 4'd0;
        cfg_fill(16'h6996);
        wr_en = 1'b0;
        mode_sel = 2'b00;
        addr = 4'd0;
        #1;
        check("R2 load priority index0", out_a, 1'b0);
        addr = 4'd1;
        #1;
        check("R2 first bit order index1", out_a, 1'b1);

        // R3/R4: table walk in lookup mode, writes attempted each step
        for (int v = 0; v < NVEC; v++) begin
            addr    = LUT_VEC[v][5:2];
            wr_data = LUT_VEC[v][1];
            wr_en   = 1'b1;
            #1;
            check("R3 lookup read", out_a, LUT_VEC[v][0]);
            tick();
            check("R4 write ignored", out_a, LUT_VEC[v][0]);
        end
        wr_en = 1'b0;

        // R5: single-port write
        mode_sel = 2'b01;
        addr = 4'd3;
        wr_data = 1'b1;
        wr_en = 1'b1;
        #1;
        check("R5 before edge", out_a, 1'b0);
        tick();
        check("R5 written", out_a, 1'b1);
        check("R7 port b off in sp", out_b, 1'b0);
        addr = 4'd4;
        wr_data = 1'b0;
        wr_en = 1'b0;
        tick();
        check("R5 no write when disabled", out_a, 1'b1);

        // R6: dual-port, same-address read-during-write
        mode_sel = 2'b10;
        rd_addr2 = 4'd3;
        addr = 4'd3;
        wr_data = 1'b0;
        wr_en = 1'b1;
        #1;
        check("R6 port b old value", out_b, 1'b1);
        tick();
        wr_en = 1'b0;
        #1;
        check("R6 port b new value", out_b, 1'b0);
        rd_addr2 = 4'd7;
        #1;
        check("R6 port b other address", out_b, 1'b1);

        // R9: mode change keeps contents
        mode_sel = 2'b00;
        tick();
        addr = 4'd3;
        #1;
        check("R9 patched bit kept", out_a, 1'b0);
        addr = 4'd4;
        #1;
        check("R9 untouched bit kept", out_a, 1'b1);
        addr = 4'd14;
        #1;
        check("R9 table bit kept", out_a, 1'b1);

        // R8: shift mode
        rst = 1'b1;
        tick();
        rst = 1'b0;
        mode_sel = 2'b11;
        wr_en = 1'b1;
        wr_data = 1'b1;
        tick();
        wr_data = 1'b0;
        addr = 4'd0;
        #1;
        check("R8 tap0 delay1", out_a, 1'b1);
        for (int k = 0; k < 5; k++) tick();
        addr = 4'd5;
        #1;
        check("R8 tap5", out_a, 1'b1);
        addr = 4'd4;
        #1;
        check("R8 tap4 empty", out_a, 1'b0);
        wr_en = 1'b0;
        tick();
        addr = 4'd5;
        #1;
        check("R8 hold when disabled", out_a, 1'b1);
        wr_en = 1'b1;
        for (int k = 0; k < 10; k++) tick();
        addr = 4'd15;
        #1;
        check("R8 tap15 delay16", out_a, 1'b1);
        tick();
        #1;
        check("R8 shifted out", out_a, 1'b0);
        wr_en = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule